// File: doc/BRIEF.md
# Key-Sequence Watchdog Timer

A watchdog counter running on the bus clock. Software picks one of seven power-of-two timeout periods, or turns the watchdog off, through a small control register. Software must then restart the counter within that period by writing a two-byte key to a separate arm register. If the deadline passes, the block raises a reset request. The request is a pulse of fixed length that the system reset logic consumes.

The arm register checks what software writes to it. A restart happens only when 0x55 is followed directly by 0xAA. A stray 0xAA does nothing. Any byte that is not a key raises the reset request at once. The control and arm registers share a plain write port made of an address, a data byte and a strobe.

Top module: `wdog_keyseq`

## Requirements
- R1: The control register sits at address 0 and uses bits [2:0] as the period field. Value 0 disables the watchdog. Values 1 to 7 select timeouts of 2^(E−SCALE_DOWN) bus cycles, where E is 14, 16, 18, 20, 22, 23 and 24 in that order.
- R2: While the watchdog is enabled, `rst_req` rises exactly one timeout period of clock edges after the edge that last restarted the counter.
- R3: The arm register sits at address 1. Writing 0x55 to it and then 0xAA as the next arm write restarts the counter at the 0xAA edge.
- R4: A 0xAA that does not directly follow 0x55 does not restart the counter, and it clears any pending 0x55. Writing 0x55 twice in a row still leaves the sequence armed for the 0xAA.
- R5: While the watchdog is enabled, an arm-register write of any value other than 0x55 or 0xAA makes `rst_req` high in the next cycle.
- R6: A reset request lasts exactly PULSE_LEN cycles. A new cause of reset that arrives during a pulse neither retriggers nor lengthens it. The counter holds at zero while the pulse is active.
- R7: After `rst_n` is released, `rst_req` is low, the period field is 0 (disabled), and both the counter and the pending-0x55 state are clear.
- R8: A control-register write loads the period field and restarts the counter. A write to any other address has no effect.
- R9: While the period field is 0, `rst_req` never rises, including after bad key writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address (0 control, 1 arm) |
| wr_data | input | 8 | Write data |
| rst_req | output | 1 | Reset request pulse |

## Verification
The bench builds the block with SCALE_DOWN set to 10 and PULSE_LEN at its default of 16. This turns the seven periods into 16 to 16384 cycles, so every setting of the period field, including the longest, times out within the run. Each timeout is measured to the exact edge from the last restart. The short periods make it cheap to repeat randomized rearm patterns, misplaced key bytes, pulses that collide with bad keys, and resets that land in the middle of a key sequence.

// File: rtl/wdog_keyseq.sv
module wdog_keyseq #(
  parameter int ADDR_W     = 2,
  parameter int CTRL_ADDR  = 0,
  parameter int ARM_ADDR   = 1,
  parameter int SCALE_DOWN = 0,
  parameter int PULSE_LEN  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              rst_req
);
  localparam int CNT_W = 25 - SCALE_DOWN;
  localparam int PW    = $clog2(PULSE_LEN + 1);
  localparam logic [7:0] KEY_A = 8'h55;
  localparam logic [7:0] KEY_B = 8'hAA;

  logic [2:0]       period_sel;
  logic             key_armed;
  logic [CNT_W-1:0] count;
  logic [PW-1:0]    pulse_cnt;

  function automatic logic [CNT_W-1:0] last_tick(input logic [2:0] s);
    int e;
    case (s)
      3'd2:    e = 16;
      3'd3:    e = 18;
      3'd4:    e = 20;
      3'd5:    e = 22;
      3'd6:    e = 23;
      3'd7:    e = 24;
      default: e = 14;
    endcase
    return CNT_W'((64'd1 << (e - SCALE_DOWN)) - 64'd1);
  endfunction

  logic ctrl_wr, arm_wr, key_a, key_b, bad_key;
  logic enabled, pulsing, rearm, restart, expired, fire;

  assign ctrl_wr = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));
  assign arm_wr  = wr_en && (wr_addr == ADDR_W'(ARM_ADDR));
  assign key_a   = arm_wr && (wr_data == KEY_A);
  assign key_b   = arm_wr && (wr_data == KEY_B);
  assign bad_key = arm_wr && !key_a && !key_b;
  assign enabled = (period_sel != 3'd0);
  assign pulsing = (pulse_cnt != '0);
  assign rearm   = key_b && key_armed;
  assign restart = rearm || ctrl_wr;
  assign expired = enabled && (count == last_tick(period_sel));
  assign fire    = enabled && !pulsing && (bad_key || (expired && !restart));
  assign rst_req = pulsing;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_sel <= 3'd0;
      key_armed  <= 1'b0;
      count      <= '0;
      pulse_cnt  <= '0;
    end else begin
      if (ctrl_wr) period_sel <= wr_data[2:0];

      if (key_a)                 key_armed <= 1'b1;
      else if (arm_wr || fire)   key_armed <= 1'b0;

      if (fire || restart || !enabled || pulsing) count <= '0;
      else                                         count <= count + 1'b1;

      if (fire)         pulse_cnt <= PW'(PULSE_LEN);
      else if (pulsing) pulse_cnt <= pulse_cnt - 1'b1;
    end
  end
endmodule

// File: rtl/wdog_keyseq_chk.sv
module wdog_keyseq_chk #(
  parameter int ADDR_W    = 2,
  parameter int CTRL_ADDR = 0,
  parameter int ARM_ADDR  = 1,
  parameter int CNT_W     = 25,
  parameter int PULSE_LEN = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic              rst_req,
  input logic [2:0]        period_sel,
  input logic              key_armed,
  input logic [CNT_W-1:0]  count
);
  logic [15:0] hi_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hi_cnt <= '0;
    else if (rst_req) hi_cnt <= hi_cnt + 1'b1;
    else              hi_cnt <= '0;
  end

  logic arm_w;
  assign arm_w = wr_en && (wr_addr == ADDR_W'(ARM_ADDR));

  p_pulse_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_req) |-> (hi_cnt == 16'(PULSE_LEN)));

  p_count_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (count == '0));

  p_disabled_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (period_sel == 3'd0 && !rst_req) |=> !rst_req);

  p_bad_key_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_w && wr_data != 8'h55 && wr_data != 8'hAA && period_sel != 3'd0 && !rst_req)
    |=> rst_req);

  p_rearm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_w && wr_data == 8'hAA && key_armed) |=> (count == '0 && !key_armed));

  p_arm_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_w && wr_data == 8'h55) |=> key_armed);

  p_lone_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_w && wr_data == 8'hAA && !key_armed && !rst_req && period_sel != 3'd0 && count != '0)
    |=> (rst_req || count != '0));
endmodule

bind wdog_keyseq wdog_keyseq_chk #(
  .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .ARM_ADDR(ARM_ADDR),
  .CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rst_req(rst_req), .period_sel(period_sel), .key_armed(key_armed), .count(count)
);

// File: tb/tb_wdog_keyseq.sv
`timescale 1ns/1ps
module tb_wdog_keyseq;
  localparam int SC = 10;
  localparam int PL = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic rst_req;

  int checks = 0;
  int fails = 0;
  longint cyc = 0;
  bit done = 0;

  wdog_keyseq #(.SCALE_DOWN(SC), .PULSE_LEN(PL)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rst_req(rst_req));

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic longint period_of(int s);
    int e;
    case (s)
      1: e = 14; 2: e = 16; 3: e = 18; 4: e = 20;
      5: e = 22; 6: e = 23; default: e = 24;
    endcase
    return longint'(1) << (e - SC);
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_rise(output longint at);
    while (!rst_req) @(negedge clk);
    at = cyc;
  endtask

  task automatic pulse_count(output int m);
    m = 0;
    while (rst_req) begin @(negedge clk); m++; end
  endtask

  task automatic settle();
    int m;
    pulse_count(m);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    longint e0, e1, at;
    int m;
    void'($urandom(32'd2024));

    idle(3);
    rst_n = 1'b1;
    idle(1);
    chk(rst_req == 1'b0, "R7 reset rst_req", rst_req, 0);

    // R9 / R7: disabled after reset, long wait and bad key
    idle(20000);
    chk(rst_req == 1'b0, "R9 disabled wait", rst_req, 0);
    wr(2'd1, 8'h12);
    idle(2);
    chk(rst_req == 1'b0, "R9 bad key while disabled", rst_req, 0);

    // R1 R2: every period
    for (int s = 1; s <= 7; s++) begin
      wr(2'd0, 8'(s));
      e0 = cyc;
      wait_rise(at);
      chk(at - e0 == period_of(s), $sformatf("R1 R2 period sel=%0d", s), at - e0, period_of(s));
      pulse_count(m);
      chk(m == PL, "R6 pulse length", m, PL);
    end

    // R5 R6: bad key fires at once, second bad key inside the pulse is ignored
    wr(2'd0, 8'd3);
    idle(5);
    wr(2'd1, 8'h33);
    chk(rst_req == 1'b1, "R5 bad key immediate", rst_req, 1);
    wr(2'd1, 8'h77);
    pulse_count(m);
    chk(m + 1 == PL, "R6 no retrigger", m + 1, PL);
    idle(1);
    chk(rst_req == 1'b0, "R6 stays low after pulse", rst_req, 0);

    // R4: lone 0xAA does not restart
    wr(2'd0, 8'd2);
    e0 = cyc;
    idle(10);
    wr(2'd1, 8'hAA);
    wait_rise(at);
    chk(at - e0 == period_of(2), "R4 lone AA ignored", at - e0, period_of(2));
    settle();

    // R4: 55 55 AA restarts
    wr(2'd0, 8'd2);
    idle(20);
    wr(2'd1, 8'h55); wr(2'd1, 8'h55); wr(2'd1, 8'hAA);
    e1 = cyc;
    wait_rise(at);
    chk(at - e1 == period_of(2), "R4 double 55 then AA", at - e1, period_of(2));
    settle();

    // R4: AA after a completed sequence is not another restart
    wr(2'd0, 8'd2);
    wr(2'd1, 8'h55); wr(2'd1, 8'hAA);
    e1 = cyc;
    idle(10);
    wr(2'd1, 8'hAA);
    wait_rise(at);
    chk(at - e1 == period_of(2), "R4 second AA ignored", at - e1, period_of(2));
    settle();

    // R8: other addresses ignored, control rewrite restarts
    wr(2'd0, 8'd2);
    e0 = cyc;
    idle(5);
    wr(2'd2, 8'h00); wr(2'd3, 8'h33);
    chk(rst_req == 1'b0, "R8 other address no fire", rst_req, 0);
    wait_rise(at);
    chk(at - e0 == period_of(2), "R8 other address no restart", at - e0, period_of(2));
    settle();
    wr(2'd0, 8'd2);
    idle(40);
    wr(2'd0, 8'd2);
    e1 = cyc;
    wait_rise(at);
    chk(at - e1 == period_of(2), "R8 control write restarts", at - e1, period_of(2));
    settle();

    // R7: reset in mid-sequence clears pending 0x55 and disables
    wr(2'd0, 8'd1);
    wr(2'd1, 8'h55);
    rst_n = 1'b0; idle(2); rst_n = 1'b1;
    idle(1);
    chk(rst_req == 1'b0, "R7 rst_req after reset", rst_req, 0);
    idle(100);
    chk(rst_req == 1'b0, "R7 disabled after reset", rst_req, 0);
    wr(2'd0, 8'd1);
    e0 = cyc;
    idle(3);
    wr(2'd1, 8'hAA);
    wait_rise(at);
    chk(at - e0 == period_of(1), "R7 key state cleared", at - e0, period_of(1));
    settle();

    // R3 R2: random rearm patterns
    for (int it = 0; it < 30; it++) begin
      int s, n, lim, g;
      s = 1 + int'($urandom_range(2));
      lim = int'(period_of(s));
      wr(2'd0, 8'(s));
      e1 = cyc;
      n = int'($urandom_range(3));
      for (int k = 0; k < n; k++) begin
        g = int'($urandom_range(lim - 4));
        idle(g);
        wr(2'd1, 8'h55); wr(2'd1, 8'hAA);
        e1 = cyc;
      end
      wait_rise(at);
      chk(at - e1 == period_of(s), $sformatf("R3 random rearm it=%0d", it), at - e1, period_of(s));
      settle();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule